// File: doc/BRIEF.md
# Typed-Attribute Write-Back Data Cache

This block is a small direct-mapped data cache. Every core request carries page attributes with it: a memory type, a three-bit permission field and a flag that says whether the page has a real memory backing. The block behaves differently for each memory type. Write-back lines stay in the cache until they are evicted. Write-through stores also go out to memory. Uncacheable accesses skip the cache completely. Allocate-type lines may exist only in the cache, with nothing behind them in memory.

Allocate-type lines are scratch storage, for example a call stack or memory used during early boot before DRAM is ready. A line with no backing memory is pinned: the cache refuses any action that would push it out to memory. Freeing any allocate line drops it without a writeback, even when it is dirty. Ordinary loads and stores obey the permission field. Stack-frame push and pop operations ignore it, so they can reach frame lines that normal code cannot touch.

The core holds `req_valid` and its fields steady until it sees a one-cycle `req_ready` pulse. The memory side moves one word per handshake.

Top module: `typed_dcache`

## Requirements
- R1: After reset all lines are invalid, `req_ready`, `resp_err` and `mem_req` are low, and the first cacheable load misses.
- R2: Encodings are: type 0 write-back, 1 write-through, 2 uncacheable, 3 allocate; op 0 load, 1 store, 2 frame read, 3 frame write, 4 free, 5 clean. Address bits [1:0] select the word, [5:2] the line, [11:6] form the tag. A cacheable miss reads the four words of the line from memory, lowest word first, and returns the requested word. A hit makes no memory access.
- R3: A write-back store hit updates the cache only. A later miss on a line whose victim is valid and dirty first writes the victim's four words back to the victim's address, then fills the new line.
- R4: A write-through store updates the cache and makes exactly one memory write of that word to its address. It leaves the line clean.
- R5: An uncacheable load or store makes exactly one memory transaction and leaves the cache contents unchanged.
- R6: A miss by an allocate request with `req_has_addr`=0 fills the line with zeros and reads nothing from memory.
- R7: A miss whose victim is a valid allocate line with no backing address is refused: `resp_err` is set, there is no memory traffic and the victim line is kept.
- R8: Free (op 4) on a hit allocate-type line invalidates the line with no memory write, even if the line is dirty.
- R9: Free on a hit dirty line of any other type writes the line back and then invalidates it. Free on a miss does nothing.
- R10: Clean (op 5) on a hit dirty line writes it back and keeps it valid and clean. Clean on a dirty allocate line with no backing address is refused with `resp_err`.
- R11: Permission bits are [2] read, [1] write, [0] execute. A load faults when all three bits are 0. A store faults when bit [1] is 0. A fault sets `resp_err`, makes no memory access and changes no state.
- R12: Frame read and frame write ignore the permission bits.
- R13: `req_ready` lasts one cycle and `resp_err` is only high together with it. `mem_req` and its address, direction and write data stay steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_op | input | 3 | Operation kind |
| req_type | input | 2 | Memory type from page attributes |
| req_perm | input | 3 | Read/write/execute permission |
| req_has_addr | input | 1 | Page has a backing memory address |
| req_addr | input | 12 | Word address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, valid with `req_ready` |
| resp_err | output | 1 | Fault or refusal, valid with `req_ready` |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory handshake, one cycle per word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The bench drives one sequence through all three stages of an allocate line's life: a zero fill, a refused eviction by a conflicting load, and a free that sends nothing to memory. A design that wrote such lines back would show memory writes the bench does not expect. A design that evicted a pinned line would return the wrong data when the line is read again. A free or clean on a dirty write-back line must produce the full four-word writeback in order. Faulting loads and stores must leave both memory and the cached data untouched, and frame operations on pages with permission 000 must still complete.

// File: rtl/typed_dcache_pkg.sv
`timescale 1ns/1ps
package typed_dcache_pkg;
  typedef enum logic [1:0] {
    MT_WB = 2'd0,
    MT_WT = 2'd1,
    MT_UC = 2'd2,
    MT_AL = 2'd3
  } mtype_e;

  typedef enum logic [2:0] {
    OP_LD    = 3'd0,
    OP_ST    = 3'd1,
    OP_FRD   = 3'd2,
    OP_FWR   = 3'd3,
    OP_FREE  = 3'd4,
    OP_CLEAN = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_ACC, S_MEM, S_DONE
  } ctl_st_e;

  typedef enum logic [1:0] {
    AFT_FILL, AFT_INV, AFT_CLEAN
  } wb_next_e;
endpackage

// File: rtl/tdc_rst_sync.sv
`timescale 1ns/1ps
module tdc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tdc_meta_store.sv
`timescale 1ns/1ps
module tdc_meta_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic             w_valid,
  input  logic             w_dirty,
  input  logic [1:0]       w_type,
  input  logic             w_has,
  input  logic [TAG_W-1:0] w_tag,
  output logic             r_valid,
  output logic             r_dirty,
  output logic [1:0]       r_type,
  output logic             r_has,
  output logic [TAG_W-1:0] r_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [LINES-1:0] has_q;
  logic [1:0]       type_q [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic line_we;
    assign line_we = we && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_q[g] <= 1'b0;
      else if (line_we) valid_q[g] <= w_valid;
    end

    always_ff @(posedge clk) begin
      if (line_we) begin
        dirty_q[g] <= w_dirty;
        has_q[g]   <= w_has;
        type_q[g]  <= w_type;
        tag_q[g]   <= w_tag;
      end
    end
  end

  assign r_valid = valid_q[idx];
  assign r_dirty = dirty_q[idx];
  assign r_has   = has_q[idx];
  assign r_type  = type_q[idx];
  assign r_tag   = tag_q[idx];
endmodule

// File: rtl/tdc_data_store.sv
`timescale 1ns/1ps
module tdc_data_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/tdc_ctrl.sv
`timescale 1ns/1ps
module tdc_ctrl
  import typed_dcache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [2:0]             req_op,
  input  logic [1:0]             req_type,
  input  logic [2:0]             req_perm,
  input  logic                   req_has_addr,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic [DATA_W-1:0]      resp_rdata,
  output logic                   resp_err,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic                   mem_ack,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic [IDX_W-1:0]       meta_idx,
  output logic                   meta_we,
  output logic                   meta_w_valid,
  output logic                   meta_w_dirty,
  output logic [1:0]             meta_w_type,
  output logic                   meta_w_has,
  output logic [TAG_W-1:0]       meta_w_tag,
  input  logic                   m_valid,
  input  logic                   m_dirty,
  input  logic [1:0]             m_type,
  input  logic                   m_has,
  input  logic [TAG_W-1:0]       m_tag,
  output logic [IDX_W+OFF_W-1:0] dat_raddr,
  input  logic [DATA_W-1:0]      dat_rdata,
  output logic                   dat_we,
  output logic [IDX_W+OFF_W-1:0] dat_waddr,
  output logic [DATA_W-1:0]      dat_wdata
);
  localparam logic [OFF_W-1:0] CNT_ONE  = OFF_W'(1);
  localparam logic [OFF_W-1:0] CNT_LAST = '1;

  ctl_st_e           st_q, st_n;
  wb_next_e          wbn_q, wbn_n;
  logic [OFF_W-1:0]  cnt_q, cnt_n;
  logic              err_q, err_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic              cap_en;

  op_e               r_op;
  mtype_e            r_type;
  logic [2:0]        r_perm;
  logic              r_has;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;

  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [OFF_W-1:0]  r_off;
  logic              hit, pinned, is_acc, is_wr, fault, zero_fill, fill_step;

  assign r_off = r_addr[OFF_W-1:0];
  assign r_idx = r_addr[OFF_W +: IDX_W];
  assign r_tag = r_addr[ADDR_W-1 -: TAG_W];

  assign hit       = m_valid && (m_tag == r_tag);
  assign pinned    = m_valid && (m_type == MT_AL) && !m_has;
  assign is_acc    = (r_op == OP_LD) || (r_op == OP_ST) || (r_op == OP_FRD) || (r_op == OP_FWR);
  assign is_wr     = (r_op == OP_ST) || (r_op == OP_FWR);
  assign fault     = ((r_op == OP_LD) && (r_perm == 3'b000)) ||
                     ((r_op == OP_ST) && !r_perm[1]);
  assign zero_fill = (r_type == MT_AL) && !r_has;
  assign meta_idx  = r_idx;

  always_comb begin
    st_n         = st_q;
    wbn_n        = wbn_q;
    cnt_n        = cnt_q;
    err_n        = err_q;
    rdata_n      = rdata_q;
    cap_en       = 1'b0;
    fill_step    = 1'b0;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = r_addr;
    mem_wdata    = r_wdata;
    meta_we      = 1'b0;
    meta_w_valid = m_valid;
    meta_w_dirty = m_dirty;
    meta_w_type  = m_type;
    meta_w_has   = m_has;
    meta_w_tag   = m_tag;
    dat_raddr    = {r_idx, r_off};
    dat_we       = 1'b0;
    dat_waddr    = {r_idx, cnt_q};
    dat_wdata    = '0;

    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          err_n  = 1'b0;
          cnt_n  = '0;
          st_n   = S_LOOK;
        end
      end

      S_LOOK: begin
        st_n = S_DONE;
        if (is_acc) begin
          if (fault) begin
            err_n = 1'b1;
          end else if (r_type == MT_UC) begin
            st_n = S_MEM;
          end else if (hit) begin
            st_n = S_ACC;
          end else if (pinned) begin
            err_n = 1'b1;
          end else if (m_valid && m_dirty) begin
            wbn_n = AFT_FILL;
            st_n  = S_WB;
          end else begin
            st_n = S_FILL;
          end
        end else if (r_op == OP_FREE) begin
          if (hit) begin
            if ((m_type == MT_AL) || !m_dirty) begin
              meta_we      = 1'b1;
              meta_w_valid = 1'b0;
            end else begin
              wbn_n = AFT_INV;
              st_n  = S_WB;
            end
          end
        end else if (r_op == OP_CLEAN) begin
          if (hit && m_dirty) begin
            if (pinned) begin
              err_n = 1'b1;
            end else begin
              wbn_n = AFT_CLEAN;
              st_n  = S_WB;
            end
          end
        end
      end

      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {m_tag, r_idx, cnt_q};
        dat_raddr = {r_idx, cnt_q};
        mem_wdata = dat_rdata;
        if (mem_ack) begin
          cnt_n = cnt_q + CNT_ONE;
          if (cnt_q == CNT_LAST) begin
            unique case (wbn_q)
              AFT_FILL: st_n = S_FILL;
              AFT_INV: begin
                meta_we      = 1'b1;
                meta_w_valid = 1'b0;
                st_n         = S_DONE;
              end
              default: begin
                meta_we      = 1'b1;
                meta_w_dirty = 1'b0;
                st_n         = S_DONE;
              end
            endcase
          end
        end
      end

      S_FILL: begin
        if (zero_fill) begin
          dat_we    = 1'b1;
          fill_step = 1'b1;
        end else begin
          mem_req  = 1'b1;
          mem_addr = {r_tag, r_idx, cnt_q};
          if (mem_ack) begin
            dat_we    = 1'b1;
            dat_wdata = mem_rdata;
            fill_step = 1'b1;
          end
        end
        if (fill_step) begin
          cnt_n = cnt_q + CNT_ONE;
          if (cnt_q == CNT_LAST) begin
            meta_we      = 1'b1;
            meta_w_valid = 1'b1;
            meta_w_dirty = 1'b0;
            meta_w_type  = r_type;
            meta_w_has   = r_has;
            meta_w_tag   = r_tag;
            st_n         = S_ACC;
          end
        end
      end

      S_ACC: begin
        st_n = S_DONE;
        if (is_wr) begin
          dat_we    = 1'b1;
          dat_waddr = {r_idx, r_off};
          dat_wdata = r_wdata;
          if (r_type == MT_WT) begin
            st_n = S_MEM;
          end else begin
            meta_we      = 1'b1;
            meta_w_dirty = 1'b1;
          end
        end else begin
          rdata_n = dat_rdata;
        end
      end

      S_MEM: begin
        mem_req = 1'b1;
        mem_we  = is_wr;
        if (mem_ack) begin
          if (!is_wr) rdata_n = mem_rdata;
          st_n = S_DONE;
        end
      end

      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      wbn_q <= AFT_FILL;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      wbn_q <= wbn_n;
      cnt_q <= cnt_n;
      err_q <= err_n;
    end
  end

  always_ff @(posedge clk) begin
    rdata_q <= rdata_n;
    if (cap_en) begin
      r_op    <= op_e'(req_op);
      r_type  <= mtype_e'(req_type);
      r_perm  <= req_perm;
      r_has   <= req_has_addr;
      r_addr  <= req_addr;
      r_wdata <= req_wdata;
    end
  end

  assign req_ready  = (st_q == S_DONE);
  assign resp_err   = err_q && (st_q == S_DONE);
  assign resp_rdata = rdata_q;
endmodule

// File: rtl/typed_dcache.sv
`timescale 1ns/1ps
module typed_dcache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_type,
  input  logic [2:0]        req_perm,
  input  logic              req_has_addr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int DEPTH = LINES * WORDS;

  logic                   srst_n;
  logic [IDX_W-1:0]       meta_idx;
  logic                   meta_we, meta_w_valid, meta_w_dirty, meta_w_has;
  logic [1:0]             meta_w_type;
  logic [TAG_W-1:0]       meta_w_tag;
  logic                   m_valid, m_dirty, m_has;
  logic [1:0]             m_type;
  logic [TAG_W-1:0]       m_tag;
  logic [IDX_W+OFF_W-1:0] dat_raddr, dat_waddr;
  logic [DATA_W-1:0]      dat_rdata, dat_wdata;
  logic                   dat_we;

  tdc_rst_sync rst_i (.clk(clk), .arst_n(rst_n), .rst_n_o(srst_n));

  tdc_meta_store #(.LINES(LINES), .TAG_W(TAG_W)) meta_i (
    .clk(clk), .rst_n(srst_n), .idx(meta_idx), .we(meta_we),
    .w_valid(meta_w_valid), .w_dirty(meta_w_dirty), .w_type(meta_w_type),
    .w_has(meta_w_has), .w_tag(meta_w_tag),
    .r_valid(m_valid), .r_dirty(m_dirty), .r_type(m_type),
    .r_has(m_has), .r_tag(m_tag)
  );

  tdc_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) data_i (
    .clk(clk), .raddr(dat_raddr), .rdata(dat_rdata),
    .we(dat_we), .waddr(dat_waddr), .wdata(dat_wdata)
  );

  tdc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) ctrl_i (
    .clk(clk), .rst_n(srst_n),
    .req_valid(req_valid), .req_op(req_op), .req_type(req_type),
    .req_perm(req_perm), .req_has_addr(req_has_addr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .resp_rdata(resp_rdata),
    .resp_err(resp_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata),
    .meta_idx(meta_idx), .meta_we(meta_we), .meta_w_valid(meta_w_valid),
    .meta_w_dirty(meta_w_dirty), .meta_w_type(meta_w_type),
    .meta_w_has(meta_w_has), .meta_w_tag(meta_w_tag),
    .m_valid(m_valid), .m_dirty(m_dirty), .m_type(m_type),
    .m_has(m_has), .m_tag(m_tag),
    .dat_raddr(dat_raddr), .dat_rdata(dat_rdata), .dat_we(dat_we),
    .dat_waddr(dat_waddr), .dat_wdata(dat_wdata)
  );
endmodule

// File: rtl/tdc_checker.sv
`timescale 1ns/1ps
module tdc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_err,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);
  a_r13_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r13_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> req_ready);

  a_r13_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r13_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

  a_r13_no_mem_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
endmodule

bind typed_dcache tdc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_err(resp_err),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/typed_dcache_tb_top.sv
`timescale 1ns/1ps
module typed_dcache_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [1:0]  req_type;
  logic [2:0]  req_perm;
  logic        req_has_addr;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        req_ready;
  logic [31:0] resp_rdata;
  logic        resp_err;
  logic        mem_req, mem_we, mem_ack;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  string cur_rq = "R1";

  typed_dcache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_type(req_type), .req_perm(req_perm), .req_has_addr(req_has_addr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_rdata(resp_rdata), .resp_err(resp_err), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memories: bench-side backing store and the model's view of it
  logic [31:0] mem_arr [4096];
  logic [31:0] ref_mem [4096];
  logic [43:0] exp_wq [$];
  int          rd_seen;

  // behavioural reference cache state
  bit          mv [16];
  bit          md [16];
  bit          mh [16];
  int          mt [16];
  logic [5:0]  mtg [16];
  logic [31:0] mdat [16][4];

  bit          exp_err, exp_chk;
  logic [31:0] exp_rdata;
  int          exp_reads;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (mem_we) begin
        if (exp_wq.size() == 0) begin
          chk(1'b0, cur_rq, "unexpected memory write", {20'd0, mem_addr}, 32'd0);
        end else begin
          logic [43:0] e;
          e = exp_wq.pop_front();
          chk(e[43:32] == mem_addr, cur_rq, "write address", {20'd0, mem_addr}, {20'd0, e[43:32]});
          chk(e[31:0] == mem_wdata, cur_rq, "write data", mem_wdata, e[31:0]);
        end
        mem_arr[mem_addr] = mem_wdata;
      end else begin
        mem_rdata <= mem_arr[mem_addr];
        rd_seen++;
      end
      mem_ack <= 1'b1;
    end
  end

  task automatic push_wr(input logic [11:0] a, input logic [31:0] d);
    exp_wq.push_back({a, d});
    ref_mem[a] = d;
  endtask

  task automatic model(input int op, input int typ, input logic [2:0] perm,
                       input bit has, input logic [11:0] a, input logic [31:0] wd);
    int idx, off;
    bit hit, pinned, acc, wr, flt;
    idx = int'(a[5:2]);
    off = int'(a[1:0]);
    hit = mv[idx] && (mtg[idx] == a[11:6]);
    pinned = mv[idx] && (mt[idx] == 3) && !mh[idx];
    acc = (op <= 3);
    wr = (op == 1) || (op == 3);
    flt = ((op == 0) && (perm == 3'b000)) || ((op == 1) && !perm[1]);
    exp_err = 1'b0; exp_chk = 1'b0; exp_reads = 0; exp_rdata = '0;
    if (acc) begin
      if (flt) exp_err = 1'b1;
      else if (typ == 2) begin
        if (wr) push_wr(a, wd);
        else begin exp_reads = 1; exp_rdata = ref_mem[a]; exp_chk = 1'b1; end
      end else begin
        if (!hit) begin
          if (pinned) exp_err = 1'b1;
          else begin
            if (mv[idx] && md[idx])
              for (int w = 0; w < 4; w++) push_wr({mtg[idx], a[5:2], 2'(w)}, mdat[idx][w]);
            for (int w = 0; w < 4; w++)
              mdat[idx][w] = (typ == 3 && !has) ? 32'd0 : ref_mem[{a[11:2], 2'(w)}];
            if (!(typ == 3 && !has)) exp_reads = 4;
            mv[idx] = 1'b1; md[idx] = 1'b0; mt[idx] = typ; mh[idx] = has; mtg[idx] = a[11:6];
          end
        end
        if (!exp_err) begin
          if (wr) begin
            mdat[idx][off] = wd;
            if (typ == 1) push_wr(a, wd);
            else md[idx] = 1'b1;
          end else begin
            exp_rdata = mdat[idx][off]; exp_chk = 1'b1;
          end
        end
      end
    end else if (op == 4) begin
      if (hit) begin
        if (mt[idx] != 3 && md[idx])
          for (int w = 0; w < 4; w++) push_wr({a[11:2], 2'(w)}, mdat[idx][w]);
        mv[idx] = 1'b0;
      end
    end else if (op == 5) begin
      if (hit && md[idx]) begin
        if (pinned) exp_err = 1'b1;
        else begin
          for (int w = 0; w < 4; w++) push_wr({a[11:2], 2'(w)}, mdat[idx][w]);
          md[idx] = 1'b0;
        end
      end
    end
  endtask

  task automatic do_req(input int op, input int typ, input logic [2:0] perm,
                        input bit has, input logic [11:0] a, input logic [31:0] wd,
                        input string rq);
    model(op, typ, perm, has, a, wd);
    @(negedge clk);
    cur_rq = rq;
    rd_seen = 0;
    req_op = 3'(op); req_type = 2'(typ); req_perm = perm;
    req_has_addr = has; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b0;
    chk(resp_err == exp_err, rq, "resp_err", {31'd0, resp_err}, {31'd0, exp_err});
    if (exp_chk) chk(resp_rdata == exp_rdata, rq, "read data", resp_rdata, exp_rdata);
    chk(rd_seen == exp_reads, rq, "memory reads", 32'(rd_seen), 32'(exp_reads));
    chk(exp_wq.size() == 0, rq, "missing memory writes", 32'(exp_wq.size()), 32'd0);
    exp_wq.delete();
    @(negedge clk);
    chk(!req_ready, "R13", "ready pulse width", {31'd0, req_ready}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog expired: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem_arr[i] = 32'h5A00_0000 | i;
      ref_mem[i] = 32'h5A00_0000 | i;
    end
    for (int i = 0; i < 16; i++) begin mv[i] = 0; md[i] = 0; mh[i] = 0; mt[i] = 0; end
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_type = '0; req_perm = '0;
    req_has_addr = 1'b0; req_addr = '0; req_wdata = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req_ready && !resp_err && !mem_req, "R1", "idle outputs after reset",
        {29'd0, req_ready, resp_err, mem_req}, 32'd0);

    do_req(0, 0, 3'b110, 1, 12'h010, 0, "R1");              // first load misses
    do_req(0, 0, 3'b110, 1, 12'h011, 0, "R2");              // hit, no traffic
    do_req(1, 0, 3'b110, 1, 12'h012, 32'h1111_2222, "R3");  // store hit, cache only
    do_req(0, 0, 3'b110, 1, 12'h012, 0, "R3");
    do_req(0, 0, 3'b110, 1, 12'h110, 0, "R3");              // dirty victim written back
    do_req(1, 1, 3'b110, 1, 12'h020, 32'hABCD_0001, "R4");  // write-through miss
    do_req(1, 1, 3'b110, 1, 12'h021, 32'hABCD_0002, "R4");  // write-through hit
    do_req(1, 2, 3'b110, 1, 12'h110, 32'hDEAD_0001, "R5");  // uncacheable store
    do_req(0, 0, 3'b110, 1, 12'h110, 0, "R5");              // cached copy untouched
    do_req(0, 2, 3'b110, 1, 12'h110, 0, "R5");              // uncacheable load
    do_req(3, 3, 3'b000, 0, 12'h030, 32'hCAFE_0001, "R6");  // zero fill, perm 000
    do_req(2, 3, 3'b000, 0, 12'h031, 0, "R6");
    do_req(2, 3, 3'b000, 0, 12'h030, 0, "R12");
    do_req(0, 3, 3'b000, 0, 12'h030, 0, "R11");             // load perm 000 faults
    do_req(1, 3, 3'b000, 0, 12'h030, 32'h0BAD_0BAD, "R11");
    do_req(0, 0, 3'b110, 1, 12'h230, 0, "R7");              // pinned victim refused
    do_req(2, 3, 3'b000, 0, 12'h030, 0, "R7");
    do_req(5, 3, 3'b000, 0, 12'h030, 0, "R10");             // clean refused
    do_req(4, 3, 3'b000, 0, 12'h030, 0, "R8");              // free discards
    do_req(0, 0, 3'b110, 1, 12'h230, 0, "R8");
    do_req(3, 3, 3'b000, 1, 12'h040, 32'hF00D_0040, "R8");  // backed allocate line
    do_req(4, 3, 3'b000, 1, 12'h040, 0, "R8");
    do_req(0, 0, 3'b110, 1, 12'h040, 0, "R8");
    do_req(1, 0, 3'b110, 1, 12'h050, 32'h5050_5050, "R9");
    do_req(4, 0, 3'b110, 1, 12'h050, 0, "R9");              // dirty free writes back
    do_req(4, 0, 3'b110, 1, 12'h050, 0, "R9");              // free on miss
    do_req(0, 0, 3'b110, 1, 12'h052, 0, "R9");
    do_req(1, 0, 3'b110, 1, 12'h060, 32'h6060_6060, "R10");
    do_req(5, 0, 3'b110, 1, 12'h060, 0, "R10");             // clean writes back
    do_req(4, 0, 3'b110, 1, 12'h060, 0, "R10");             // now clean: no write
    do_req(1, 0, 3'b101, 1, 12'h041, 32'h7777_7777, "R11"); // no write permission
    do_req(0, 0, 3'b001, 1, 12'h041, 0, "R11");             // load allowed
    do_req(2, 0, 3'b000, 1, 12'h041, 0, "R12");
    do_req(3, 0, 3'b000, 1, 12'h041, 32'h1212_1212, "R12");
    do_req(0, 0, 3'b100, 1, 12'h041, 0, "R12");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule